// File: doc/BRIEF.md
# Tearing-Effect Transfer Gate

This block decides when a display transfer may start, based on the tearing-effect (TE) signal that a panel drives. Each request comes with a 2-bit mode. The block can release the transfer at once. It can also wait for a rising or a falling TE transition, then wait an optional number of slow-timer periods, and only then release it. If the chosen transition does not arrive within a programmable number of slow-timer periods, the block drops the request and raises a timeout pulse instead.

Time is measured in periods of a slow tick. That tick comes from two power-of-two dividers in series. The first divides the clock by 2^r0 and the second divides the first by 2^r1. Each exponent is 0 to 15, so one period is 2^(r0+r1) clocks. The dividers restart when a wait begins, so each window is exact to the clock. The TE pin is asynchronous and passes through a two-flop synchroniser before edge detection. A typical setting is r0 = 8, r1 = 9, a timeout of 16 periods and no post-edge wait.

Top module: `te_gate`

## Requirements
- R1: After a synchronous reset, `go`, `te_timeout` and `busy` are all low.
- R2: A request with mode 0 makes `go` high for exactly one cycle, right after the clock edge that accepts the request. `busy` stays low and TE is not consulted.
- R3: Mode 3 behaves exactly like mode 0.
- R4: Mode 1 waits for a low-to-high TE transition. Count the clock edges from the first one that samples the new TE level as edge 1. With a zero post-edge wait, `go` pulses after edge 3. Falling transitions do not count.
- R5: Mode 2 waits for a high-to-low TE transition, with the same latency as R4. Rising transitions do not count.
- R6: With a post-edge wait of W > 0 periods, `go` pulses W·2^(r0+r1) clocks after the edge at which R4/R5 would have released it.
- R7: If the selected transition has not acted by N·2^(r0+r1) clocks after the accepting edge, `te_timeout` pulses for one cycle at that point, and `go` never pulses for that request. N is the timeout count. An edge that acts on the same clock edge as the expiry wins.
- R8: `busy` is high from the accepting edge of a mode 1 or mode 2 request until its `go` or `te_timeout`. Requests that arrive while `busy` is high are ignored.
- R9: A timeout count of 0 behaves as a count of 1.
- R10: `go` and `te_timeout` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Function clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Transfer request, sampled when not busy |
| req_mode | input | 2 | 0/3 no sync, 1 rising TE, 2 falling TE |
| te_async | input | 1 | Tearing-effect pin from the panel, asynchronous |
| div0_exp | input | 4 | First divider exponent r0 |
| div1_exp | input | 4 | Second divider exponent r1 |
| timeout_ticks | input | TW | Timeout N in slow periods |
| wait_ticks | input | TW | Post-edge wait W in slow periods |
| go | output | 1 | One-cycle transfer release |
| te_timeout | output | 1 | One-cycle timeout event |
| busy | output | 1 | Waiting on TE or post-edge delay |

## Verification
Directed cases cover each mode with the correct transition, the opposite transition, and no transition. They tell apart the edge selection, the no-sync bypass and the timeout path. Randomised transactions vary both divider exponents, the timeout and the wait, and place the TE transition before, at and after expiry. The case where edge and expiry land together separates the priority rule from an off-by-one in the period count. Requests injected while the block is busy show whether it ignores them.

// File: rtl/te_gate_pkg.sv
package te_gate_pkg;
  typedef enum logic [1:0] {S_IDLE = 2'd0, S_WAIT = 2'd1, S_HOLD = 2'd2} tg_state_t;
  localparam logic [1:0] MODE_RISE = 2'd1;
  localparam logic [1:0] MODE_FALL = 2'd2;
endpackage

// File: rtl/te_edge_sync.sv
module te_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic te_async,
  output logic rise,
  output logic fall
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= te_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;

  // R4: a detected rising transition cannot repeat on the next cycle
  p_rise_single_r4: assert property (@(posedge clk) disable iff (rst) rise |=> !rise);
endmodule

// File: rtl/te_timebase.sv
module te_timebase #(
  parameter int RW = 4,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [RW-1:0] div0_exp,
  input  logic [RW-1:0] div1_exp,
  output logic          tick
);
  logic [CW-1:0] c0_q, c1_q, lim0, lim1;
  logic          t0;

  assign lim0 = (CW'(1) << div0_exp) - CW'(1);
  assign lim1 = (CW'(1) << div1_exp) - CW'(1);
  assign t0   = (c0_q == lim0);
  assign tick = t0 && (c1_q == lim1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      c0_q <= '0;
      c1_q <= '0;
    end else if (t0) begin
      c0_q <= '0;
      c1_q <= tick ? '0 : c1_q + CW'(1);
    end else begin
      c0_q <= c0_q + CW'(1);
    end
  end
endmodule

// File: rtl/te_seq.sv
module te_seq
  import te_gate_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_mode,
  input  logic          edge_rise,
  input  logic          edge_fall,
  input  logic          tick,
  input  logic [TW-1:0] timeout_ticks,
  input  logic [TW-1:0] wait_ticks,
  output logic          go,
  output logic          te_timeout,
  output logic          busy,
  output logic          tb_clr
);
  tg_state_t     state;
  logic          sel_fall;
  logic [TW-1:0] cnt;
  logic [TW:0]   cnt_inc;
  logic          is_sync, edge_hit;

  assign cnt_inc  = {1'b0, cnt} + (TW+1)'(1);
  assign is_sync  = (req_mode == MODE_RISE) || (req_mode == MODE_FALL);
  assign edge_hit = sel_fall ? edge_fall : edge_rise;
  assign tb_clr   = ((state == S_IDLE) && req_valid && is_sync) ||
                    ((state == S_WAIT) && edge_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      go         <= 1'b0;
      te_timeout <= 1'b0;
      busy       <= 1'b0;
      cnt        <= '0;
      sel_fall   <= 1'b0;
    end else begin
      go         <= 1'b0;
      te_timeout <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          if (is_sync) begin
            state    <= S_WAIT;
            busy     <= 1'b1;
            cnt      <= '0;
            sel_fall <= (req_mode == MODE_FALL);
          end else begin
            go <= 1'b1;
          end
        end
        S_WAIT: begin
          if (edge_hit) begin
            if (wait_ticks == '0) begin
              go    <= 1'b1;
              state <= S_IDLE;
              busy  <= 1'b0;
            end else begin
              state <= S_HOLD;
              cnt   <= '0;
            end
          end else if (tick) begin
            if (cnt_inc >= {1'b0, timeout_ticks}) begin
              te_timeout <= 1'b1;
              state      <= S_IDLE;
              busy       <= 1'b0;
            end else begin
              cnt <= cnt_inc[TW-1:0];
            end
          end
        end
        S_HOLD: if (tick) begin
          if (cnt_inc >= {1'b0, wait_ticks}) begin
            go    <= 1'b1;
            state <= S_IDLE;
            busy  <= 1'b0;
          end else begin
            cnt <= cnt_inc[TW-1:0];
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: a release lasts one cycle
  p_go_pulse_r2: assert property (@(posedge clk) disable iff (rst) go |=> !go);
  // R2, R3: unsynchronised request released on the next edge
  p_fast_go_r2: assert property (@(posedge clk) disable iff (rst)
    ((state == S_IDLE) && req_valid && !is_sync) |=> go);
  // R10: release and timeout are exclusive
  p_excl_r10: assert property (@(posedge clk) disable iff (rst) !(go && te_timeout));
  // R7: expiry only on a slow tick
  p_to_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
    ((state == S_WAIT) && !tick) |=> !te_timeout);
  // R6: post-edge wait ends only on a slow tick
  p_hold_tick_r6: assert property (@(posedge clk) disable iff (rst)
    ((state == S_HOLD) && !tick) |=> !go);
endmodule

// File: rtl/te_gate.sv
module te_gate #(
  parameter int TW = 8,
  parameter int RW = 4,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_mode,
  input  logic          te_async,
  input  logic [RW-1:0] div0_exp,
  input  logic [RW-1:0] div1_exp,
  input  logic [TW-1:0] timeout_ticks,
  input  logic [TW-1:0] wait_ticks,
  output logic          go,
  output logic          te_timeout,
  output logic          busy
);
  logic rise, fall, tick, tb_clr;

  te_edge_sync u_sync (
    .clk(clk), .rst(rst), .te_async(te_async), .rise(rise), .fall(fall)
  );

  te_timebase #(.RW(RW), .CW(CW)) u_tb (
    .clk(clk), .rst(rst), .clr(tb_clr), .div0_exp(div0_exp),
    .div1_exp(div1_exp), .tick(tick)
  );

  te_seq #(.TW(TW)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .edge_rise(rise), .edge_fall(fall), .tick(tick),
    .timeout_ticks(timeout_ticks), .wait_ticks(wait_ticks),
    .go(go), .te_timeout(te_timeout), .busy(busy), .tb_clr(tb_clr)
  );
endmodule

// File: tb/te_gate_bench.sv
`timescale 1ns/1ps
module te_gate_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       req_valid;
  logic [1:0] req_mode;
  logic       te_async;
  logic [3:0] div0_exp, div1_exp;
  logic [7:0] timeout_ticks, wait_ticks;
  logic       go, te_timeout, busy;
  int n_checks = 0, n_fail = 0;

  always #10 clk = ~clk;

  te_gate u_te_gate (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .te_async(te_async), .div0_exp(div0_exp), .div1_exp(div1_exp),
    .timeout_ticks(timeout_ticks), .wait_ticks(wait_ticks),
    .go(go), .te_timeout(te_timeout), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected outcome: returns cycle of event; is_go tells go vs timeout
  function automatic int exp_time(input int mode, input int r0, input int r1,
      input int n, input int w, input int kind, input int ts, output bit is_go);
    int p, ne, act;
    p  = 1 << (r0 + r1);
    ne = (n == 0) ? 1 : n;
    if (mode == 0 || mode == 3) begin is_go = 1; return 0; end
    act = ts + 2;
    if (kind == 1 && act <= ne * p) begin is_go = 1; return act + w * p; end
    is_go = 0;
    return ne * p;
  endfunction

  // kind: 0 no transition, 1 selected transition, 2 opposite transition
  task automatic run_txn(input string tag, input int mode, input int r0, input int r1,
      input int n, input int w, input int kind, input int ts, input bit extra);
    bit is_go, start_lvl;
    int et, first_go, first_to, go_cnt, busy1, lim;
    et = exp_time(mode, r0, r1, n, w, kind, ts, is_go);
    start_lvl = (mode == 2) ? (kind != 2) : (kind == 2);
    @(negedge clk);
    div0_exp = 4'(r0); div1_exp = 4'(r1);
    timeout_ticks = 8'(n); wait_ticks = 8'(w);
    te_async = start_lvl;
    repeat (4) @(negedge clk);
    req_valid = 1'b1; req_mode = 2'(mode);
    @(posedge clk); #1;
    first_go = go ? 0 : -1; first_to = te_timeout ? 0 : -1;
    go_cnt = go ? 1 : 0; busy1 = 0;
    lim = et + 6;
    for (int t = 1; t <= lim; t++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (extra && t == 2 && et >= 4) begin req_valid = 1'b1; req_mode = 2'd0; end
      if (kind != 0 && t == ts) te_async = ~start_lvl;
      @(posedge clk); #1;
      if (t == 1) busy1 = busy;
      if (go) begin go_cnt++; if (first_go < 0) first_go = t; end
      if (te_timeout && first_to < 0) first_to = t;
    end
    if (is_go) begin
      check({tag, " go time"}, first_go, et);
      check({tag, " no timeout R10"}, first_to, -1);
    end else begin
      check({tag, " timeout time R7"}, first_to, et);
      check({tag, " no go after timeout R7"}, go_cnt, 0);
    end
    if (is_go) check({tag, " single go R8"}, go_cnt, 1);
    if (mode == 1 || mode == 2) begin
      if (et > 1) check({tag, " busy while waiting R8"}, busy1, 1);
    end else check({tag, " busy low R2"}, busy1, 0);
    check({tag, " busy low at end R8"}, int'(busy), 0);
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    int seed = 7;
    void'($urandom(seed));
    rst = 1'b1; req_valid = 1'b0; req_mode = 2'd0; te_async = 1'b0;
    div0_exp = 4'd0; div1_exp = 4'd0; timeout_ticks = 8'd4; wait_ticks = 8'd0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset go", int'(go), 0);
    check("R1 reset timeout", int'(te_timeout), 0);
    check("R1 reset busy", int'(busy), 0);
    @(negedge clk); rst = 1'b0;

    run_txn("R2 mode0", 0, 1, 1, 2, 0, 0, 0, 0);
    run_txn("R3 mode3", 3, 1, 1, 2, 0, 0, 0, 0);
    run_txn("R4 rise", 1, 1, 0, 4, 0, 1, 3, 0);
    run_txn("R4 wrong fall", 1, 1, 0, 3, 0, 2, 2, 0);
    run_txn("R5 fall", 2, 0, 1, 4, 0, 1, 2, 0);
    run_txn("R5 wrong rise", 2, 0, 1, 3, 0, 2, 2, 0);
    run_txn("R6 wait", 2, 1, 1, 5, 2, 1, 4, 0);
    run_txn("R6 big period", 1, 3, 2, 2, 1, 1, 10, 0);
    run_txn("R7 no edge", 1, 1, 1, 3, 0, 0, 0, 0);
    run_txn("R7 tie edge wins", 1, 0, 0, 3, 0, 1, 1, 0);
    run_txn("R7 late edge", 1, 0, 0, 3, 0, 1, 2, 0);
    run_txn("R9 zero timeout", 2, 1, 1, 0, 0, 0, 0, 0);
    run_txn("R8 ignored req", 1, 1, 1, 4, 1, 1, 6, 1);

    for (int i = 0; i < 60; i++) begin
      int md, r0, r1, n, w, kd, ts;
      md = int'($urandom_range(3, 0));
      r0 = int'($urandom_range(1, 0));
      r1 = int'($urandom_range(2, 0));
      n  = int'($urandom_range(4, 0));
      w  = int'($urandom_range(3, 0));
      kd = int'($urandom_range(2, 0));
      ts = int'($urandom_range(((n == 0) ? 1 : n) * (1 << (r0 + r1)) + 2, 1));
      run_txn("R4/R5/R6/R7 random", md, r0, r1, n, w, kd, ts, 1'($urandom_range(1, 0)));
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule